// File: doc/BRIEF.md
# Power-On Strap Capture and Shared-Pin Role Selector

A clock generator shares several package pins between configuration straps and runtime functions. This block holds the digital control for those pins. While power-good is low, every shared pin is an input. A pin that nothing drives settles to its pull level. On the first reference-clock edge after power-good rises, the block captures the strap levels once. It then gives each pin its runtime role: a clock output, a ratio output that carries captured frequency-select bits to the memory-controller side, or an active-low stop-request input.

Two captured straps decide what the two dual-purpose pins become. The mode strap and the ratio-select strap together make them extra PCI clock outputs, ratio outputs, or PCI/CPU stop-request inputs. Stop inputs are brought onto the reference clock through a synchronizer before they reach the stop-request outputs. When power-good drops, every pin goes back to input mode and the straps are captured again on the next rise.

Pin index order, used by `padLevel`, `padDriven`, `pinOe` and `pinRole`: 0 FS0, 1 FS1, 2 FS2, 3 FS3, 4 MODE, 5 CLKSEL (24/48), 6 RATIOSEL, 7 DUAL0, 8 DUAL1.

Top module: `strap_pin_ctrl`

## Requirements
- R1: While `pwrGood` is low, `pinOe` is all zero, every `pinRole` field is 0 (input), `fsLatched` is 0, `ratioOut` is 0 and both stop requests are 0.
- R2: On the first rising `clk` edge with `pwrGood` high, the resolved levels of pins 0..3 are captured into `fsLatched` (bit n from pin n), together with the MODE, CLKSEL and RATIOSEL levels. The result is visible after that edge.
- R3: A pin whose `padDriven` bit is 0 resolves to its pull level: low for pins 0, 1 and 5, high for pins 2, 3, 4, 6, 7 and 8. A driven pin resolves to its `padLevel` bit.
- R4: After capture, changes on any pad do not alter `fsLatched`, `clkIs24`, `ratioOut` or the role of any pin until `pwrGood` falls.
- R5: After capture, pins 0 to 5 report role 1 (clock) with their output enable set, and pin 6 stays role 0 (input) with its enable clear. `pinRole` holds pin k in bits [2k+1:2k], coded 0 input, 1 clock, 2 ratio, 3 stop.
- R6: A captured MODE=1 with RATIOSEL=1 gives pins 7 and 8 role 1 (clock) with their enables set.
- R7: A captured MODE=1 with RATIOSEL=0 gives pins 7 and 8 role 2 (ratio) with their enables set. `ratioOut` bit n then equals `fsLatched` bit n, for n = 0 and 1.
- R8: A captured MODE=0 gives pins 7 and 8 role 3 (stop) with their enables clear.
- R9: `clkIs24` equals the captured CLKSEL level: 0 selects the 48 MHz output and 1 selects 24 MHz.
- R10: With MODE=0 captured, a low on pin 7 raises `pciStopReq` and a low on pin 8 raises `cpuStopReq`. Each follows its pin after exactly two `clk` edges. With MODE=1 captured, both requests stay 0 whatever pins 7 and 8 do.
- R11: A fall of `pwrGood` returns the block to the R1 state at once, and the next rise captures the current straps afresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| pwrGood | input | 1 | Power-good; low holds the block in input mode (asynchronous) |
| padLevel | input | 9 | Level seen on each shared pin when driven |
| padDriven | input | 9 | 1 where the pin is driven externally, 0 where it floats to its pull |
| fsLatched | output | 4 | Captured frequency-select straps |
| clkIs24 | output | 1 | Captured 24/48 select, 1 = 24 MHz |
| ratioOut | output | 2 | Values driven on the dual pins in ratio role |
| pinOe | output | 9 | Per-pin output enable |
| pinRole | output | 18 | Per-pin role code, 2 bits per pin |
| pciStopReq | output | 1 | Synchronized PCI stop request, active high |
| cpuStopReq | output | 1 | Synchronized CPU stop request, active high |

## Verification
The assertions assume that `pwrGood` is the only reset. They also assume that `pwrGood` rises and falls away from the active clock edge, so that capture is one clean clock edge after the rise. The stimulus changes `pwrGood` and every pad only on the falling clock edge, and it holds `pwrGood` low for at least one full cycle before each new rise. Stop-pin levels are held steady across the two synchronizer edges, so the two-edge latency can be checked deterministically.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int NUM_PIN  = 9;
  localparam int FS_WIDTH = 4;

  localparam int PIN_FS0   = 0;
  localparam int PIN_MODE  = 4;
  localparam int PIN_CSEL  = 5;
  localparam int PIN_RSEL  = 6;
  localparam int PIN_DUAL0 = 7;
  localparam int PIN_DUAL1 = 8;

  typedef enum logic [1:0] {
    ROLE_INPUT = 2'd0,
    ROLE_CLOCK = 2'd1,
    ROLE_RATIO = 2'd2,
    ROLE_STOP  = 2'd3
  } pinRole_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // one cycle: latch straps on this edge
    logic active;   // straps held, runtime roles in force
  } ctrlStrobe_t;
endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
(
  input  logic        clk,
  input  logic        pwrGood,
  output ctrlStrobe_t strobe
);
  logic armed;

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) armed <= 1'b0;
    else          armed <= 1'b1;
  end

  assign strobe.capture = pwrGood & ~armed;
  assign strobe.active  = armed;

  AST_CAPTURE_ONCE: assert property (@(posedge clk) disable iff (!pwrGood)
    strobe.capture |=> (strobe.active && !strobe.capture)); // R2
endmodule

// File: rtl/strap_datapath.sv
module strap_datapath
  import strap_pkg::*;
#(
  parameter logic [NUM_PIN-1:0] PULL_UP = 9'h1DC,
  parameter int SYNC_STAGES = 2
)(
  input  logic                 clk,
  input  logic                 pwrGood,
  input  ctrlStrobe_t          strobe,
  input  logic [NUM_PIN-1:0]   padLevel,
  input  logic [NUM_PIN-1:0]   padDriven,
  output logic [FS_WIDTH-1:0]  fsLatched,
  output logic                 clkIs24,
  output logic [1:0]           ratioOut,
  output logic [NUM_PIN-1:0]   pinOe,
  output logic [2*NUM_PIN-1:0] pinRole,
  output logic                 pciStopReq,
  output logic                 cpuStopReq
);
  localparam int NUM_DUAL = 2;

  logic [NUM_PIN-1:0]  resolved;
  logic [FS_WIDTH-1:0] fsReg;
  logic [1:0]          ratioReg;
  logic                modeReg;
  logic                ratioSelReg;
  logic                clkSelReg;
  logic [NUM_DUAL-1:0] stopSync;
  pinRole_e            dualRole;

  // undriven pins settle to their pull level
  assign resolved = (padLevel & padDriven) | (PULL_UP & ~padDriven);

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) begin
      fsReg       <= '0;
      ratioReg    <= '0;
      modeReg     <= 1'b1;
      ratioSelReg <= 1'b1;
      clkSelReg   <= 1'b0;
    end else if (strobe.capture) begin
      fsReg       <= resolved[PIN_FS0 +: FS_WIDTH];
      ratioReg    <= resolved[PIN_FS0 +: 2];
      modeReg     <= resolved[PIN_MODE];
      ratioSelReg <= resolved[PIN_RSEL];
      clkSelReg   <= resolved[PIN_CSEL];
    end
  end

  always_comb begin
    if (!strobe.active)   dualRole = ROLE_INPUT;
    else if (!modeReg)    dualRole = ROLE_STOP;
    else if (ratioSelReg) dualRole = ROLE_CLOCK;
    else                  dualRole = ROLE_RATIO;
  end

  for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
    pinRole_e role;
    if (p == PIN_DUAL0 || p == PIN_DUAL1) begin : g_dual
      assign role = dualRole;
    end else if (p == PIN_RSEL) begin : g_rsel
      assign role = ROLE_INPUT;
    end else begin : g_clk
      assign role = strobe.active ? ROLE_CLOCK : ROLE_INPUT;
    end
    assign pinRole[2*p +: 2] = role;
    assign pinOe[p] = (role == ROLE_CLOCK) || (role == ROLE_RATIO);
  end

  for (genvar d = 0; d < NUM_DUAL; d++) begin : g_sync
    logic [SYNC_STAGES-1:0] shiftQ;
    always_ff @(posedge clk or negedge pwrGood) begin
      if (!pwrGood) shiftQ <= '1;
      else          shiftQ <= {shiftQ[SYNC_STAGES-2:0], resolved[PIN_DUAL0 + d]};
    end
    assign stopSync[d] = shiftQ[SYNC_STAGES-1];
  end

  assign pciStopReq = strobe.active & ~modeReg & ~stopSync[0];
  assign cpuStopReq = strobe.active & ~modeReg & ~stopSync[1];
  assign fsLatched  = fsReg;
  assign clkIs24    = clkSelReg;
  assign ratioOut   = ratioReg;

  AST_NO_OE_BEFORE_CAPTURE: assert property (@(posedge clk) disable iff (!pwrGood)
    !strobe.active |-> (pinOe == '0)); // R1
  AST_LATCH_STABLE: assert property (@(posedge clk) disable iff (!pwrGood)
    strobe.active |=> ($stable(fsReg) && $stable(modeReg) && $stable(clkSelReg))); // R4
  AST_RATIO_TRACKS_FS: assert property (@(posedge clk) disable iff (!pwrGood)
    strobe.active |-> (ratioReg == fsReg[1:0])); // R7
  AST_STOP_GATED: assert property (@(posedge clk) disable iff (!pwrGood)
    modeReg |-> (!pciStopReq && !cpuStopReq)); // R10
endmodule

// File: rtl/strap_pin_ctrl.sv
module strap_pin_ctrl
  import strap_pkg::*;
#(
  parameter logic [NUM_PIN-1:0] PULL_UP = 9'h1DC,
  parameter int SYNC_STAGES = 2
)(
  input  logic                 clk,
  input  logic                 pwrGood,
  input  logic [NUM_PIN-1:0]   padLevel,
  input  logic [NUM_PIN-1:0]   padDriven,
  output logic [FS_WIDTH-1:0]  fsLatched,
  output logic                 clkIs24,
  output logic [1:0]           ratioOut,
  output logic [NUM_PIN-1:0]   pinOe,
  output logic [2*NUM_PIN-1:0] pinRole,
  output logic                 pciStopReq,
  output logic                 cpuStopReq
);
  ctrlStrobe_t strobe;

  strap_ctrl u_ctrl (
    .clk     (clk),
    .pwrGood (pwrGood),
    .strobe  (strobe)
  );

  strap_datapath #(
    .PULL_UP     (PULL_UP),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .pwrGood    (pwrGood),
    .strobe     (strobe),
    .padLevel   (padLevel),
    .padDriven  (padDriven),
    .fsLatched  (fsLatched),
    .clkIs24    (clkIs24),
    .ratioOut   (ratioOut),
    .pinOe      (pinOe),
    .pinRole    (pinRole),
    .pciStopReq (pciStopReq),
    .cpuStopReq (cpuStopReq)
  );
endmodule

// File: tb/strap_pin_ctrl_tb.sv
module strap_pin_ctrl_tb;
  logic        clk = 1'b0;
  logic        pwrGood = 1'b1;
  logic [8:0]  padLevel = '0;
  logic [8:0]  padDriven = '0;
  logic [3:0]  fsLatched;
  logic        clkIs24;
  logic [1:0]  ratioOut;
  logic [8:0]  pinOe;
  logic [17:0] pinRole;
  logic        pciStopReq, cpuStopReq;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  strap_pin_ctrl u_dut (
    .clk(clk), .pwrGood(pwrGood), .padLevel(padLevel), .padDriven(padDriven),
    .fsLatched(fsLatched), .clkIs24(clkIs24), .ratioOut(ratioOut),
    .pinOe(pinOe), .pinRole(pinRole),
    .pciStopReq(pciStopReq), .cpuStopReq(cpuStopReq)
  );

  typedef struct packed {
    logic [8:0] lvl;
    logic [8:0] drv;
    logic [3:0] fs;
    logic [1:0] dual;
    logic       c24;
  } vec_t;

  // stimulus and expected results, dual role: 1 clock, 2 ratio, 3 stop
  localparam vec_t VECS [8] = '{
    '{9'b000000000, 9'b000000000, 4'b1100, 2'd1, 1'b0},
    '{9'b000000000, 9'b111111111, 4'b0000, 2'd3, 1'b0},
    '{9'b111111111, 9'b111111111, 4'b1111, 2'd1, 1'b1},
    '{9'b110110011, 9'b111111111, 4'b0011, 2'd2, 1'b1},
    '{9'b000000000, 9'b001000000, 4'b1100, 2'd2, 1'b0},
    '{9'b000000000, 9'b000010000, 4'b1100, 2'd3, 1'b0},
    '{9'b000100001, 9'b000100011, 4'b1101, 2'd1, 1'b1},
    '{9'b000000100, 9'b001001100, 4'b0100, 2'd2, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] resolve(input logic [8:0] lvl, input logic [8:0] drv);
    return (lvl & drv) | (9'b111011100 & ~drv);  // R3 pull levels
  endfunction

  function automatic logic [1:0] dualOf(input logic [8:0] res);
    if (!res[4]) return 2'd3;
    if (res[6])  return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [17:0] rolesOf(input logic [1:0] dual);
    return {dual, dual, 2'd0, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1};
  endfunction

  function automatic logic [8:0] oeOf(input logic [1:0] dual);
    logic e;
    e = (dual != 2'd3);
    return {e, e, 1'b0, 6'b111111};
  endfunction

  task automatic powerUp(input logic [8:0] lvl, input logic [8:0] drv);
    @(negedge clk);
    pwrGood = 1'b0;
    padLevel = lvl;
    padDriven = drv;
    @(negedge clk);
    pwrGood = 1'b1;
    @(negedge clk);  // capture edge passed
  endtask

  task automatic checkReset(input string req);
    chk({req, " oe"}, 32'(pinOe), 32'h0);
    chk({req, " role"}, 32'(pinRole), 32'h0);
    chk({req, " fs"}, 32'(fsLatched), 32'h0);
    chk({req, " ratio"}, 32'(ratioOut), 32'h0);
    chk({req, " stop"}, {30'h0, pciStopReq, cpuStopReq}, 32'h0);
  endtask

  task automatic checkCaptured(input string req, input logic [3:0] fs,
                               input logic [1:0] dual, input logic c24);
    chk({req, " fs"}, 32'(fsLatched), 32'(fs));
    chk({req, " R9 clkIs24"}, 32'(clkIs24), 32'(c24));
    chk({req, " R5 roles"}, 32'(pinRole), 32'(rolesOf(dual)));
    chk({req, " R5 oe"}, 32'(pinOe), 32'(oeOf(dual)));
    chk({req, " R7 ratio"}, 32'(ratioOut), 32'(fs[1:0]));
    chk({req, " stop idle"}, {30'h0, pciStopReq, cpuStopReq}, 32'h0);
  endtask

  initial begin
    #2 pwrGood = 1'b0;
    padLevel = 9'h1FF;
    padDriven = 9'h1FF;
    @(negedge clk);
    @(negedge clk);
    checkReset("R1 reset");

    // table walk: R2 R3 R6 R7 R8 R9
    for (int i = 0; i < 8; i++) begin
      powerUp(VECS[i].lvl, VECS[i].drv);
      checkCaptured($sformatf("R2/R3 vec%0d", i), VECS[i].fs, VECS[i].dual, VECS[i].c24);
    end

    // full sweep of driven strap combinations: R2 R6 R7 R8
    for (int v = 0; v < 512; v++) begin
      logic [8:0] res;
      res = resolve(9'(v), 9'h1FF);
      powerUp(9'(v), 9'h1FF);
      checkCaptured($sformatf("R2 sweep %0d", v), res[3:0], dualOf(res), res[5]);
    end

    // R4: pad changes after capture are ignored
    powerUp(9'b110111111, 9'h1FF);
    padLevel = 9'b001000000;
    padDriven = 9'b111111111;
    repeat (4) @(negedge clk);
    checkCaptured("R4 hold", 4'hF, 2'd2, 1'b1);
    padDriven = 9'h000;
    repeat (3) @(negedge clk);
    checkCaptured("R4 float", 4'hF, 2'd2, 1'b1);

    // R10: stop synchronizer with MODE=0
    powerUp(9'b111101111, 9'h1FF);
    chk("R8 stop role", 32'(pinRole[17:14]), 32'hF);
    padLevel[7] = 1'b0;
    @(negedge clk);
    chk("R10 pci latency 1 edge", 32'(pciStopReq), 32'h0);
    @(negedge clk);
    chk("R10 pci after 2 edges", 32'(pciStopReq), 32'h1);
    chk("R10 cpu idle", 32'(cpuStopReq), 32'h0);
    padLevel[8] = 1'b0;
    @(negedge clk);
    chk("R10 cpu latency 1 edge", 32'(cpuStopReq), 32'h0);
    @(negedge clk);
    chk("R10 cpu after 2 edges", 32'(cpuStopReq), 32'h1);
    padLevel[8:7] = 2'b11;
    repeat (2) @(negedge clk);
    chk("R10 release", {30'h0, pciStopReq, cpuStopReq}, 32'h0);
    padDriven[8:7] = 2'b00;  // floating stop pins pull high
    repeat (2) @(negedge clk);
    chk("R10 float inactive", {30'h0, pciStopReq, cpuStopReq}, 32'h0);

    // R10: MODE=1 keeps stop requests low
    powerUp(9'b001111111, 9'h1FF);
    repeat (4) @(negedge clk);
    chk("R10 gated mode1", {30'h0, pciStopReq, cpuStopReq}, 32'h0);

    // R11: fall returns to input, rise recaptures
    powerUp(9'b111111111, 9'h1FF);
    @(negedge clk);
    pwrGood = 1'b0;
    #1;
    checkReset("R11 fall");
    padLevel = 9'b000010010;
    @(negedge clk);
    pwrGood = 1'b1;
    @(negedge clk);
    checkCaptured("R11 recapture", 4'b0010, 2'd2, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule